// File: doc/BRIEF.md
# Eight-Pin Bidirectional Port Controller with Analog Pin Masking

This block connects eight general-purpose pins to a simple processor bus. Software sees three registers: a port data register, a direction register and a pin configuration register. Each pin is either driven from an output latch or left as a tri-stated input, depending on its direction bit. A read of the port register returns the pin levels after a two-flop synchronizer, not the latch contents. Writes to the port register land only in the output latch.

The configuration register holds a four-bit code. The code selects which of the five low pins are analog inputs, and an analog pin always reads as zero in the port register. Pin 5 can only be an input, so its direction bit reads as one whatever is written to it. Writes come in three forms: a byte write, a single-bit set and a single-bit clear. A bit operation reads the addressed register the way software would see it, changes one bit and writes all eight bits back. On the port register this means the pin levels are written into the latch, with analog pins contributing zero.

Two active-low resets are supported. Power-on reset clears everything. A warm reset leaves latch bits 7..5 unchanged.

Top module: `gpio_port_ctrl`

## Requirements
- R1: A direction bit of 1 turns the pin's driver off (`pin_oe` bit 0). A direction bit of 0 turns it on (`pin_oe` bit 1), and then `pin_out` carries that bit of the output latch.
- R2: A read of the port register returns the pin levels as they were two rising clock edges earlier, after the analog mask is applied. A byte write to the port register changes only the output latch (`pin_out`), not the value read back.
- R3: Pin 5 is input-only. `pin_oe[5]` is always 0, and bit 5 of the direction register always reads 1.
- R4: The configuration register reads as {ctl[1:0], 2'b00, code[3:0]}. Bits 7..6 store whatever is written to them. Bits 5..4 always read 0.
- R5: The analog mask is decoded from the code. Let n = code[2:0]. When code[3]=0, pin i (for i<5) is analog when i+n<5: code 0000 makes pins 4..0 analog, and codes 0101 to 0111 (including 0110) make every pin digital. When code[3]=1, only pin n is analog, provided n<5. Pins 7..5 are never analog. Analog pins read 0 in the port register.
- R6: `bus_op` selects the write form: 00 is a byte write, 01 sets bit `bus_bit`, 10 clears bit `bus_bit`, and 11 is ignored. A set or clear starts from the register's read value: for the port register this is the masked, synchronized pin levels; for the other registers it is their own read-back value.
- R7: After power-on reset (`por_n` low), the latch is 0x00, the direction register reads 0xFF and the configuration register reads 0x00. After a warm reset (`rst_n` low), latch bits 4..0 clear, latch bits 7..5 keep their value, the direction register reads 0xFF and the configuration register reads 0x00.
- R8: The address map is 0 for the port register, 1 for direction and 2 for configuration. Address 3 reads 0 and ignores writes. `bus_rdata` is 0 whenever `bus_rd` is low.
- R9: Read data is combinational: it is valid in the same cycle that `bus_addr` and `bus_rd` are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| rst_n | input | 1 | Warm reset, active low, asynchronous assert |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_op | input | 2 | Write form: byte, set bit or clear bit |
| bus_bit | input | 3 | Bit index for set and clear |
| bus_wdata | input | 8 | Write data for byte writes |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Output latch value sent to the pads |
| pin_oe | output | 8 | Per-pin driver enable, 1 = driving |

## Verification
A wrong latch shows up on `pin_out` one edge after the write that caused it. A wrong direction bit shows up on `pin_oe` within the same edge. A wrong synchronizer depth or a wrong mask decode shows up only through port reads, so the bench steps the pin level between edges and reads after each edge to pin down the latency. The most damaging hidden error is a bit operation that starts from the latch instead of the pins; it shows up on `pin_out` right after the set or clear. The bench therefore drives pin levels that differ from the latch, including on analog pins, before each bit operation. For warm reset, the latch bits that must survive are checked on `pin_out` right after reset is released.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int PORT_W = 8;
  localparam int BIT_W  = $clog2(PORT_W);
  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    REG_PORT = 2'd0,
    REG_DIR  = 2'd1,
    REG_CFG  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    OP_BYTE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_RSVD = 2'd3
  } wr_op_e;

  // Read-modify-write: start from the visible value, touch one bit or replace all.
  function automatic logic [PORT_W-1:0] apply_op(
    input wr_op_e            op,
    input logic [BIT_W-1:0]  bsel,
    input logic [PORT_W-1:0] cur,
    input logic [PORT_W-1:0] wdat
  );
    logic [PORT_W-1:0] r;
    r = cur;
    case (op)
      OP_BYTE: r = wdat;
      OP_SET:  r[bsel] = 1'b1;
      OP_CLR:  r[bsel] = 1'b0;
      default: r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = d_async;
      end else begin : g_next
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_cfg_decode.sv
module gpio_cfg_decode #(
  parameter int PORT_W    = 8,
  parameter int CODE_W    = 4,
  parameter int ANA_PINS  = 5
) (
  input  logic [CODE_W-1:0] code,
  output logic [PORT_W-1:0] analog_mask
);

  localparam int IDX_W = CODE_W - 1;

  logic             single_mode;
  logic [IDX_W-1:0] idx;

  assign single_mode = code[CODE_W-1];
  assign idx         = code[IDX_W-1:0];

  generate
    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      if (i < ANA_PINS) begin : g_ana
        assign analog_mask[i] = single_mode ? (int'(idx) == i)
                                            : ((int'(idx) + i) < ANA_PINS);
      end else begin : g_dig
        assign analog_mask[i] = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int IN_ONLY_PIN = 5,
  parameter int ANA_PINS    = 5,
  parameter int KEEP_LSB    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [1:0]        bus_op,
  input  logic [BIT_W-1:0]  bus_bit,
  input  logic [PORT_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe
);

  localparam logic [PORT_W-1:0] IN_ONLY_MASK = PORT_W'(1) << IN_ONLY_PIN;
  localparam int                HI_W         = PORT_W - KEEP_LSB;
  localparam int                CTL_W        = 2;
  localparam int                GAP_W        = PORT_W - CTL_W - CODE_W;

  // Reset release synchronisation
  logic por_s_n, sys_s_n;

  gpio_rst_sync #(.STAGES(2)) u_por_sync (
    .clk    (clk),
    .arst_n (por_n),
    .srst_n (por_s_n)
  );

  gpio_rst_sync #(.STAGES(2)) u_sys_sync (
    .clk    (clk),
    .arst_n (por_n & rst_n),
    .srst_n (sys_s_n)
  );

  // Pin input path
  logic [PORT_W-1:0] pins_sync;

  gpio_in_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk     (clk),
    .rst_n   (por_s_n),
    .d_async (pin_in),
    .q_sync  (pins_sync)
  );

  // Register state
  logic [KEEP_LSB-1:0] latch_lo_q, latch_lo_d;
  logic [HI_W-1:0]     latch_hi_q, latch_hi_d;
  logic [PORT_W-1:0]   dir_q, dir_d;
  logic [CTL_W-1:0]    ctl_q, ctl_d;
  logic [CODE_W-1:0]   code_q, code_d;
  logic                latch_en, dir_en, cfg_en;

  logic [PORT_W-1:0] analog_mask;

  gpio_cfg_decode #(.PORT_W(PORT_W), .CODE_W(CODE_W), .ANA_PINS(ANA_PINS)) u_cfg_decode (
    .code        (code_q),
    .analog_mask (analog_mask)
  );

  // Visible register values
  logic [PORT_W-1:0] port_rd, dir_rd, cfg_rd, sel_rd, wr_val;
  logic [PORT_W-1:0] latch_q;
  reg_sel_e          sel;
  wr_op_e            op;

  always_comb begin
    sel     = reg_sel_e'(bus_addr);
    op      = wr_op_e'(bus_op);
    latch_q = {latch_hi_q, latch_lo_q};
    port_rd = pins_sync & ~analog_mask;
    dir_rd  = dir_q | IN_ONLY_MASK;
    cfg_rd  = {ctl_q, {GAP_W{1'b0}}, code_q};
    case (sel)
      REG_PORT: sel_rd = port_rd;
      REG_DIR:  sel_rd = dir_rd;
      REG_CFG:  sel_rd = cfg_rd;
      default:  sel_rd = '0;
    endcase
  end

  assign bus_rdata = bus_rd ? sel_rd : '0;

  // Next-state logic
  always_comb begin
    wr_val     = apply_op(op, bus_bit, sel_rd, bus_wdata);
    latch_en   = bus_wr && (sel == REG_PORT) && (op != OP_RSVD);
    dir_en     = bus_wr && (sel == REG_DIR)  && (op != OP_RSVD);
    cfg_en     = bus_wr && (sel == REG_CFG)  && (op != OP_RSVD);
    latch_lo_d = latch_en ? wr_val[KEEP_LSB-1:0]      : latch_lo_q;
    latch_hi_d = latch_en ? wr_val[PORT_W-1:KEEP_LSB] : latch_hi_q;
    dir_d      = dir_en   ? (wr_val | IN_ONLY_MASK)   : dir_q;
    ctl_d      = cfg_en   ? wr_val[PORT_W-1:PORT_W-CTL_W] : ctl_q;
    code_d     = cfg_en   ? wr_val[CODE_W-1:0]        : code_q;
  end

  // Registers cleared by any reset
  always_ff @(posedge clk or negedge sys_s_n) begin
    if (!sys_s_n) begin
      latch_lo_q <= '0;
      dir_q      <= '1;
      ctl_q      <= '0;
      code_q     <= '0;
    end else begin
      latch_lo_q <= latch_lo_d;
      dir_q      <= dir_d;
      ctl_q      <= ctl_d;
      code_q     <= code_d;
    end
  end

  // Upper latch bits survive a warm reset
  always_ff @(posedge clk or negedge por_s_n) begin
    if (!por_s_n) latch_hi_q <= '0;
    else          latch_hi_q <= latch_hi_d;
  end

  assign pin_out = latch_q;
  assign pin_oe  = ~dir_rd;

  // Assertions
  assert_dir_byte_write_R1: assert property (@(posedge clk) disable iff (!sys_s_n)
    (bus_wr && bus_addr == 2'd1 && bus_op == 2'd0)
      |=> (pin_oe == (~$past(bus_wdata) & ~IN_ONLY_MASK)));

  assert_port_byte_write_R2: assert property (@(posedge clk) disable iff (!sys_s_n)
    (bus_wr && bus_addr == 2'd0 && bus_op == 2'd0) |=> (pin_out == $past(bus_wdata)));

  assert_input_only_R3: assert property (@(posedge clk) disable iff (!sys_s_n)
    pin_oe[IN_ONLY_PIN] == 1'b0);

  assert_cfg_gap_R4: assert property (@(posedge clk) disable iff (!sys_s_n)
    (bus_rd && bus_addr == 2'd2) |-> (bus_rdata[PORT_W-CTL_W-1:CODE_W] == '0));

  assert_analog_zero_R5: assert property (@(posedge clk) disable iff (!sys_s_n)
    (bus_rd && bus_addr == 2'd0) |-> ((bus_rdata & analog_mask) == '0));

  assert_rsvd_op_R6: assert property (@(posedge clk) disable iff (!sys_s_n)
    (bus_wr && bus_op == 2'd3) |=> ($stable(pin_out) && $stable(pin_oe)));

  assert_idle_read_R8: assert property (@(posedge clk) disable iff (!sys_s_n)
    (!bus_rd) |-> (bus_rdata == '0));

endmodule

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;

  logic       clk = 1'b0;
  logic       por_n, rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr;
  logic [1:0] bus_op;
  logic [2:0] bus_bit;
  logic [7:0] bus_wdata;
  logic       bus_rd;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in, pin_out, pin_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  gpio_port_ctrl u_gpio_port_ctrl (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_op    (bus_op),
    .bus_bit   (bus_bit),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] op, input logic [2:0] b,
                    input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_op = op; bus_bit = b; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic set_pins(input logic [7:0] p);
    @(negedge clk);
    pin_in = p;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_mask(input logic [3:0] c);
    logic [7:0] m = '0;
    for (int i = 0; i < 5; i++) begin
      if (c[3]) m[i] = (int'(c[2:0]) == i);
      else      m[i] = (int'(c[2:0]) + i < 5);
    end
    return m;
  endfunction

  task automatic do_reset(input bit por);
    @(negedge clk);
    if (por) por_n = 1'b0; else rst_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state;
    logic [7:0] v;
    rd(2'd1, v); check("R7 dir after POR", v, 8'hFF);
    rd(2'd2, v); check("R7 cfg after POR", v, 8'h00);
    check("R7 latch after POR", pin_out, 8'h00);
    check("R1 no driver with dir=1", pin_oe, 8'h00);
    rd(2'd3, v); check("R8 unmapped read", v, 8'h00);
    @(negedge clk); bus_addr = 2'd1; #1;
    check("R8 rdata idle", bus_rdata, 8'h00);
  endtask

  task automatic t_analog_codes;
    logic [7:0] v;
    set_pins(8'hFF);
    rd(2'd0, v); check("R5 code 0000 pins 4..0 analog", v, 8'hE0);
    for (int c = 0; c < 16; c++) begin
      wr(2'd2, 2'd0, 3'd0, 8'hF0 | 8'(c));
      rd(2'd2, v); check("R4 cfg readback", v, 8'hC0 | 8'(c));
      rd(2'd0, v); check("R5 masked port read", v, 8'hFF & ~exp_mask(4'(c)));
    end
  endtask

  task automatic t_direction;
    logic [7:0] v;
    wr(2'd2, 2'd0, 3'd0, 8'h06);
    wr(2'd1, 2'd0, 3'd0, 8'h00);
    rd(2'd1, v); check("R3 dir bit5 reads 1", v, 8'h20);
    check("R3/R1 pin_oe after dir=0", pin_oe, 8'hDF);
    wr(2'd0, 2'd0, 3'd0, 8'h5A);
    check("R1 pin_out from latch", pin_out, 8'h5A);
    set_pins(8'h33);
    rd(2'd0, v); check("R2 read returns pins not latch", v, 8'h33);
    wr(2'd1, 2'd0, 3'd0, 8'hF0);
    check("R1 mixed directions", pin_oe, 8'h0F);
  endtask

  task automatic t_sync_delay;
    logic [7:0] v;
    set_pins(8'h33);
    @(negedge clk); pin_in = 8'hCC;
    bus_addr = 2'd0; bus_rd = 1'b1; #1;
    check("R9 same-cycle read, old level", bus_rdata, 8'h33);
    @(negedge clk); #1;
    check("R2 after one edge still old", bus_rdata, 8'h33);
    @(negedge clk); #1;
    check("R2 after two edges new level", bus_rdata, 8'hCC);
    bus_rd = 1'b0;
  endtask

  task automatic t_bit_ops;
    logic [7:0] v;
    wr(2'd2, 2'd0, 3'd0, 8'h06);
    wr(2'd0, 2'd0, 3'd0, 8'h00);
    set_pins(8'hA0);
    wr(2'd0, 2'd1, 3'd1, 8'h00);
    check("R6 set uses pin levels", pin_out, 8'hA2);
    wr(2'd0, 2'd2, 3'd7, 8'hFF);
    check("R6 clear uses pin levels", pin_out, 8'h20);
    wr(2'd2, 2'd0, 3'd0, 8'h00);
    set_pins(8'hFF);
    wr(2'd0, 2'd2, 3'd6, 8'h00);
    check("R6 analog pins clear latch", pin_out, 8'hA0);
    wr(2'd0, 2'd3, 3'd0, 8'h55);
    check("R6 reserved op ignored on port", pin_out, 8'hA0);
    wr(2'd1, 2'd0, 3'd0, 8'h00);
    wr(2'd1, 2'd1, 3'd0, 8'h00);
    rd(2'd1, v); check("R6 set on dir", v, 8'h21);
    wr(2'd1, 2'd2, 3'd5, 8'h00);
    rd(2'd1, v); check("R3 clear of dir bit5 ignored", v, 8'h21);
    wr(2'd2, 2'd1, 3'd5, 8'h00);
    rd(2'd2, v); check("R4 set of gap bit ignored", v, 8'h00);
    wr(2'd2, 2'd1, 3'd7, 8'h00);
    rd(2'd2, v); check("R4 set of ctl bit", v, 8'h80);
    wr(2'd3, 2'd0, 3'd0, 8'hFF);
    rd(2'd3, v); check("R8 unmapped write ignored", v, 8'h00);
    check("R8 unmapped write leaves latch", pin_out, 8'hA0);
  endtask

  task automatic t_warm_reset;
    logic [7:0] v;
    wr(2'd2, 2'd0, 3'd0, 8'h06);
    wr(2'd0, 2'd0, 3'd0, 8'hE7);
    wr(2'd1, 2'd0, 3'd0, 8'h00);
    do_reset(1'b0);
    check("R7 warm reset keeps bits 7..5", pin_out, 8'hE0);
    rd(2'd1, v); check("R7 dir after warm reset", v, 8'hFF);
    rd(2'd2, v); check("R7 cfg after warm reset", v, 8'h00);
    wr(2'd0, 2'd0, 3'd0, 8'hE7);
    do_reset(1'b1);
    check("R7 POR clears latch", pin_out, 8'h00);
  endtask

  initial begin
    por_n = 1'b0; rst_n = 1'b0;
    bus_addr = '0; bus_wr = 1'b0; bus_op = '0; bus_bit = '0;
    bus_wdata = '0; bus_rd = 1'b0; pin_in = '0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_analog_codes();
    t_direction();
    t_sync_delay();
    t_bit_ops();
    t_warm_reset();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule